// File: doc/BRIEF.md
# Pipelined Serial ADC Command Front End

This block sits between a byte-wide host register bus and one or more 8-channel, 16-bit serial converters. Each converter has its own slot in the register space, four byte addresses wide. A host write to a slot's command register opens a full-duplex serial frame on that slot. The new 8-bit configuration word goes out on the data-out line while the converter returns the 16-bit result of the conversion it performed for the previous command. Results therefore always lag their commands by one frame, so the first result read after a reconfiguration is stale.

The command byte is not interpreted here and reaches the converter unchanged. Its fields are: bit 7, single-ended when set and differential when clear; bit 6, picks the odd member of a channel pair; bits 5:4, the channel pair; bits 3:2, one of four input ranges (±5 V, ±10 V, 0–5 V, 0–10 V). Bipolar results arrive as two's complement and are passed through untouched.

When a frame ends, the result is split into a low byte and a high byte, and a ready flag rises in the slot's status byte. A write to the command register while a frame is running is refused and recorded in a sticky overrun bit. The serial clock comes from the system clock through a parameterised divider.

Top module: `adc_cmd_front`

## Requirements
- R1: After a synchronous reset every slot has chip-select high, serial clock low, all four registers reading 0x00, and the interrupt output low.
- R2: Register offsets within a slot are: result low byte at 0, result high byte at 1, command at 2, status at 3. Slot n starts at byte address 4·n. Read data is registered and shows the register addressed in the previous cycle.
- R3: A command write to an idle slot drives that slot's chip-select low at the next clock edge. Chip-select stays low for exactly 16 serial clock periods (32·CLK_DIV system clocks). The serial clock idles low whenever chip-select is high.
- R4: During a frame the data-out line carries the command MSB first over the first 8 periods and then zeros. Data-out changes on falling serial clock edges. Data-in is sampled MSB first on rising serial clock edges.
- R5: At the end of a frame the 16 sampled bits become the result. This is the converter's answer to the previous command, so each result lags its command by one frame.
- R6: Status bit 7 (data ready) clears when a command write is accepted. It sets on the same clock edge at which chip-select returns high.
- R7: A command write that arrives during a frame is ignored and leaves both the command register and the frame untouched. It sets status bit 6 (overrun), which stays set until a status write with bit 6 = 1 clears it.
- R8: A status write stores bits 3:0, where bit 0 is the interrupt enable. Status bit 4 reads data-ready AND enable, and the interrupt output is the OR of that bit over all slots. Status bit 5 reads 0.
- R9: Slots run independently, and frames may overlap in time across slots.
- R10: The command register reads back the last accepted command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | $clog2(NSLOT)+2 | Byte address: slot in upper bits, register in bits 1:0 |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Any slot with ready and interrupt enable set |
| adc_sclk | output | NSLOT | Serial clock per slot |
| adc_cs_n | output | NSLOT | Active-low chip-select per slot |
| adc_mosi | output | NSLOT | Serial command out per slot |
| adc_miso | input | NSLOT | Serial result in per slot |

## Verification
A wrong bit count or divider phase in the shift engine shows up directly on the pins. Chip-select either rises before or after the edge the reference predicts, and the mismatch is caught on that very clock. A corrupted shift register or wrong bit order does not show on the pins; it surfaces only when the result bytes are read after the frame ends, one frame later than the fault. The converter stub answers with a function of the command it received, so a mangled command shows up in the result of the frame after it. A lost or stale ready, overrun or enable bit shows up in the next status read or on the interrupt pin within one clock.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  localparam int CMD_W    = 8;
  localparam int RES_W    = 16;
  localparam int OFS_LO   = 0;
  localparam int OFS_HI   = 1;
  localparam int OFS_CMD  = 2;
  localparam int OFS_STAT = 3;
  localparam int ST_READY = 7;
  localparam int ST_OVR   = 6;
  localparam int ST_IRQ   = 4;
  localparam int ST_CLEAR_OVR = 6;
endpackage

// File: rtl/adc_shift_engine.sv
module adc_shift_engine #(
  parameter int CLK_DIV = 4,
  parameter int CMD_W   = 8,
  parameter int RES_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int BIT_W = $clog2(RES_W);

  logic [DIV_W-1:0] div_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic [RES_W-1:0] tx_sh, rx_sh, res_q;
  logic sclk_q, cs_q, busy_q, tick;

  assign tick   = busy_q && (div_cnt == DIV_W'(CLK_DIV - 1));
  assign done   = tick && sclk_q && (bit_cnt == BIT_W'(RES_W - 1));
  assign busy   = busy_q;
  assign result = res_q;
  assign sclk   = sclk_q;
  assign cs_n   = cs_q;
  assign mosi   = tx_sh[RES_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      res_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      busy_q  <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      cs_q    <= 1'b0;
      sclk_q  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= {cmd, {(RES_W-CMD_W){1'b0}}};
    end else if (busy_q) begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick && !sclk_q) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[RES_W-2:0], miso};
      end
      if (tick && sclk_q) begin
        sclk_q  <= 1'b0;
        tx_sh   <= {tx_sh[RES_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
        if (done) begin
          busy_q <= 1'b0;
          cs_q   <= 1'b1;
          res_q  <= rx_sh;
        end
      end
    end
  end

  // checker: count rising serial clock edges inside one frame
  logic             sclk_prev;
  logic [BIT_W:0]   rises;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      rises     <= '0;
    end else begin
      sclk_prev <= sclk_q;
      if (cs_q && !done)
        rises <= '0;
      else if (sclk_q && !sclk_prev)
        rises <= rises + 1'b1;
    end
  end

  p_frame_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_q) |-> (rises == (BIT_W+1)'(RES_W)));
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> !sclk_q);
  p_mosi_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (!cs_q && $past(!cs_q) && sclk_q) |-> $stable(tx_sh[RES_W-1]));
endmodule

// File: rtl/adc_slot_regs.sv
module adc_slot_regs #(
  parameter int CMD_W = 8,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmd,
  input  logic             wr_stat,
  input  logic [7:0]       wdata,
  input  logic             busy,
  input  logic             done,
  output logic             start,
  output logic [CMD_W-1:0] cmd_q,
  output logic [7:0]       stat,
  output logic             ready,
  output logic             irq
);
  import adc_fe_pkg::*;

  logic       rdy_q, ovr_q;
  logic [3:0] ctl_q;

  assign start = wr_cmd && !busy;
  assign ready = rdy_q;
  assign irq   = rdy_q && ctl_q[0];
  assign stat  = {rdy_q, ovr_q, 1'b0, rdy_q & ctl_q[0], ctl_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      ctl_q <= '0;
    end else begin
      if (wr_cmd) begin
        if (busy) begin
          ovr_q <= 1'b1;
        end else begin
          cmd_q <= wdata[CMD_W-1:0];
          rdy_q <= 1'b0;
        end
      end
      if (done)
        rdy_q <= 1'b1;
      if (wr_stat) begin
        ctl_q <= wdata[3:0];
        if (wdata[ST_CLEAR_OVR])
          ovr_q <= 1'b0;
      end
    end
  end

  p_busy_write_ovr_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && busy) |=> ovr_q);
  p_busy_write_keeps_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && busy) |=> $stable(cmd_q));
  p_accept_clears_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !busy) |=> !rdy_q);
endmodule

// File: rtl/adc_cmd_front.sv
module adc_cmd_front #(
  parameter int NSLOT   = 2,
  parameter int CLK_DIV = 4,
  parameter int AW      = $clog2(NSLOT) + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    host_addr,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             irq,
  output logic [NSLOT-1:0] adc_sclk,
  output logic [NSLOT-1:0] adc_cs_n,
  output logic [NSLOT-1:0] adc_mosi,
  input  logic [NSLOT-1:0] adc_miso
);
  import adc_fe_pkg::*;

  localparam int SLOT_W = AW - 2;

  logic [SLOT_W-1:0] slot_sel;
  logic [1:0]        reg_sel;
  assign slot_sel = host_addr[AW-1:2];
  assign reg_sel  = host_addr[1:0];

  logic [7:0]       stat_a   [NSLOT];
  logic [CMD_W-1:0] cmd_a    [NSLOT];
  logic [RES_W-1:0] res_a    [NSLOT];
  logic [NSLOT-1:0] busy_v, done_v, start_v, ready_v, irq_v, wr_cmd_v, wr_stat_v;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign wr_cmd_v[g]  = host_wr && (slot_sel == SLOT_W'(g)) && (reg_sel == 2'(OFS_CMD));
    assign wr_stat_v[g] = host_wr && (slot_sel == SLOT_W'(g)) && (reg_sel == 2'(OFS_STAT));

    adc_slot_regs #(.CMD_W(CMD_W), .RES_W(RES_W)) u_regs (
      .clk(clk), .rst(rst),
      .wr_cmd(wr_cmd_v[g]), .wr_stat(wr_stat_v[g]), .wdata(host_wdata),
      .busy(busy_v[g]), .done(done_v[g]),
      .start(start_v[g]), .cmd_q(cmd_a[g]), .stat(stat_a[g]),
      .ready(ready_v[g]), .irq(irq_v[g])
    );

    adc_shift_engine #(.CLK_DIV(CLK_DIV), .CMD_W(CMD_W), .RES_W(RES_W)) u_eng (
      .clk(clk), .rst(rst),
      .start(start_v[g]), .cmd(host_wdata[CMD_W-1:0]), .miso(adc_miso[g]),
      .busy(busy_v[g]), .done(done_v[g]), .result(res_a[g]),
      .sclk(adc_sclk[g]), .cs_n(adc_cs_n[g]), .mosi(adc_mosi[g])
    );

    p_ready_at_frame_end_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(ready_v[g]) |-> $rose(adc_cs_n[g]));
    p_start_frame_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_cmd_v[g] && !busy_v[g]) |=> !adc_cs_n[g]);
  end

  logic [7:0] rd_mux;
  always_comb begin
    unique case (reg_sel)
      2'(OFS_LO):  rd_mux = res_a[slot_sel][7:0];
      2'(OFS_HI):  rd_mux = res_a[slot_sel][15:8];
      2'(OFS_CMD): rd_mux = cmd_a[slot_sel];
      default:     rd_mux = stat_a[slot_sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      irq        <= 1'b0;
    end else begin
      host_rdata <= rd_mux;
      irq        <= |irq_v;
    end
  end

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (|irq_v) |=> irq);
endmodule

// File: tb/adc_cmd_front_test.sv
module adc_cmd_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS    = 2;
  localparam int DIV   = 2;
  localparam int AW    = 3;
  localparam int FRAME = 32 * DIV;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic          host_wr = 1'b0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          irq;
  logic [NS-1:0] sclk, cs_n, mosi, miso;

  int vectors = 0;
  int fails   = 0;
  int writes  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cmd_front #(.NSLOT(NS), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .adc_sclk(sclk), .adc_cs_n(cs_n), .adc_mosi(mosi), .adc_miso(miso)
  );

  // behavioural converter answer for a given command and slot
  function automatic logic [15:0] conv(input logic [7:0] c, input int s);
    return {c ^ 8'hA5, ~c} ^ ((s == 1) ? 16'h8001 : 16'h0000);
  endfunction

  // converter stubs: answer the previous command during each frame
  for (genvar g = 0; g < NS; g++) begin : g_stub
    logic [15:0] sh = '0;
    logic [15:0] pend = '0;
    logic [7:0]  cin = '0;
    int nb = 0;
    assign miso[g] = sh[15];
    always @(negedge cs_n[g]) begin sh = pend; nb = 0; end
    always @(posedge sclk[g]) if (cs_n[g] == 1'b0) begin
      if (nb < 8) cin = {cin[6:0], mosi[g]};
      nb++;
    end
    always @(negedge sclk[g]) if (cs_n[g] == 1'b0) sh = sh << 1;
    always @(posedge cs_n[g]) if (nb == 16) begin pend = conv(cin, g); nb = 0; end
  end

  // reference model
  int         r_cnt  [NS];
  logic       r_rdy  [NS];
  logic       r_ovr  [NS];
  logic [3:0] r_ctl  [NS];
  logic [7:0] r_cmd  [NS];
  logic [15:0] r_res [NS];
  logic [15:0] r_ret [NS];
  logic [15:0] r_next[NS];
  logic [7:0] r_rd;
  logic       r_irq;

  function automatic logic [7:0] r_stat(input int s);
    return {r_rdy[s], r_ovr[s], 1'b0, r_rdy[s] & r_ctl[s][0], r_ctl[s]};
  endfunction

  always @(posedge clk) begin
    int s;
    logic [7:0] v;
    logic any;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        r_cnt[i] <= 0; r_rdy[i] <= 1'b0; r_ovr[i] <= 1'b0; r_ctl[i] <= '0;
        r_cmd[i] <= '0; r_res[i] <= '0; r_ret[i] <= '0; r_next[i] <= '0;
      end
      r_rd <= '0; r_irq <= 1'b0;
    end else begin
      s = int'(host_addr[AW-1:2]);
      case (host_addr[1:0])
        2'd0: v = r_res[s][7:0];
        2'd1: v = r_res[s][15:8];
        2'd2: v = r_cmd[s];
        default: v = r_stat(s);
      endcase
      r_rd <= v;
      any = 1'b0;
      for (int i = 0; i < NS; i++) any = any | (r_rdy[i] & r_ctl[i][0]);
      r_irq <= any;
      for (int i = 0; i < NS; i++) begin
        if (r_cnt[i] != 0) begin
          r_cnt[i] <= r_cnt[i] - 1;
          if (r_cnt[i] == 1) begin r_rdy[i] <= 1'b1; r_res[i] <= r_ret[i]; end
        end
        if (host_wr && s == i && host_addr[1:0] == 2'd2) begin
          if (r_cnt[i] != 0) r_ovr[i] <= 1'b1;
          else begin
            r_cnt[i] <= FRAME; r_rdy[i] <= 1'b0; r_cmd[i] <= host_wdata;
            r_ret[i] <= r_next[i]; r_next[i] <= conv(host_wdata, i);
          end
        end
        if (host_wr && s == i && host_addr[1:0] == 2'd3) begin
          r_ctl[i] <= host_wdata[3:0];
          if (host_wdata[6]) r_ovr[i] <= 1'b0;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  logic [1:0] last_reg;
  always @(posedge clk) last_reg <= host_addr[1:0];

  always @(negedge clk) if (!rst) begin
    string tag;
    if (writes == 0) tag = "R1";
    else case (last_reg)
      2'd0, 2'd1: tag = "R5";
      2'd2: tag = "R10";
      default: tag = "R6";
    endcase
    vectors++;
    if (host_rdata !== r_rd) begin
      fails++;
      $display("FAIL %s/R2 rdata actual=%h expected=%h t=%0t", tag, host_rdata, r_rd, $time);
    end
    vectors++;
    if (irq !== r_irq) begin
      fails++;
      $display("FAIL R8 irq actual=%b expected=%b t=%0t", irq, r_irq, $time);
    end
    for (int i = 0; i < NS; i++) begin
      vectors++;
      if (cs_n[i] !== (r_cnt[i] == 0)) begin
        fails++;
        $display("FAIL R3 cs_n[%0d] actual=%b expected=%b t=%0t", i, cs_n[i], r_cnt[i] == 0, $time);
      end
      if (cs_n[i] === 1'b1) begin
        vectors++;
        if (sclk[i] !== 1'b0) begin
          fails++;
          $display("FAIL R3 idle sclk[%0d] actual=%b expected=0 t=%0t", i, sclk[i], $time);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1; writes++;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_addr = AW'(i % 8);
    end
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sweep(16);                       // R1, R2: reset values across the map
    wr(3'd3, 8'h01);                 // R8: enable interrupt on slot 0
    wr(3'd2, 8'hC4);                 // R3, R4: first frame, stale result
    sweep(10);
    wr(3'd2, 8'h3F);                 // R7: write during a frame is ignored
    sweep(FRAME + 10);
    wr(3'd2, 8'h9C);                 // R5: result of 0xC4 arrives now
    sweep(FRAME + 10);
    wr(3'd6, 8'h55);                 // R9: overlapping frames on both slots
    wr(3'd2, 8'h21);
    sweep(FRAME / 2);
    wr(3'd6, 8'hAA);                 // R7 on slot 1
    sweep(FRAME + 10);
    wr(3'd3, 8'h4E);                 // R7 clear, R8 store control bits
    sweep(16);
    wr(3'd7, 8'h01);                 // R8 slot 1 interrupt
    wr(3'd6, 8'h0F);                 // R10, R5 slot 1 chain
    sweep(FRAME + 16);
    wr(3'd7, 8'h40);                 // R7 clear on slot 1, irq off
    sweep(16);
    finish_run();
  end
endmodule